// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

A synthesizable, cycle-based model of a small byte-wide memory that can be written only once per bit. The cell matrix is a parameterised register array that comes out of reset with every bit set. A write can only clear bits, so the stored byte becomes the bitwise AND of the old content and the byte presented. Analog conditions become two digital flags. `vpp_hi` marks the raised programming supply. `a9_hv` marks the high-voltage level on address bit 9.

The pins are active low: chip enable, output enable and program strobe. The model decodes them, with the two flags, into seven modes: read, output disable, standby, program, program verify, program inhibit and identifier read. The data bus is split into `din`, `dout` and `dout_en`. A bus wrapper ties them to a tri-state pad. Timing is counted in clock cycles. Read data appears a parameterised number of cycles after the outputs are requested. A program pulse is committed once, when the strobe returns high.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset every location reads 0xFF.
- R2: A program operation stores the bitwise AND of the byte already held and the byte on `din`, so bits can go from 1 to 0 but never back.
- R3: A write happens once, on the first cycle the strobe is sampled high after a cycle sampled in program mode. Holding the strobe low longer changes nothing. If chip enable rises while the strobe is still low, nothing is written.
- R4: With `ce_n` high and `vpp_hi` low (standby), `dout_en` is low whatever `oe_n` is.
- R5: With `ce_n` low and `oe_n` high, `dout_en` is low (output disable).
- R6: With `ce_n` low, `oe_n` low, `pgm_n` high, `vpp_hi` low and `a9_hv` low, the byte at `addr` is driven.
- R7: Program mode is `ce_n` low, `pgm_n` low and `vpp_hi` high. In this mode `dout_en` stays low. The address and `din` of the last program-mode cycle are the ones written.
- R8: With `vpp_hi` high, `ce_n` low, `oe_n` low and `pgm_n` high (verify), the stored byte at `addr` is driven.
- R9: With `vpp_hi` high and `ce_n` high (inhibit), strobe pulses write nothing and `dout_en` stays low.
- R10: With `a9_hv` high, `vpp_hi` low, `ce_n`, `oe_n` low and `pgm_n` high, the identifier is driven. It is 0x01 when `addr[0]` is 0. When `addr[0]` is 1 it is the device code: 0x08, 0x89 or 0x04 for `DEV_SEL` 0, 1 or 2.
- R11: Every identifier byte has odd parity, with bit 7 as the parity bit.
- R12: Data is driven on the `RD_LAT`-th consecutive sampled cycle with `ce_n` low, `oe_n` low and `pgm_n` high. `dout_en` falls in the first cycle after `oe_n` or `ce_n` is sampled high.
- R13: With `ce_n` low, `vpp_hi` low and `pgm_n` low, `dout_en` stays low and releasing the strobe writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restores the blank array |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | High-voltage level on address bit 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Byte driven when enabled |
| dout_en | output | 1 | Output driver enable |

## Verification
Most faults in the stored bits show up only through a later read or verify. A wrong armed flag, latched address or latched data therefore shows as a wrong byte on the first read of that location. That read is `RD_LAT` cycles after the outputs are opened. A fault in the latency counter or the mode decode shows on `dout_en` in the very next cycle. A miscounted run moves the enable edge by a cycle. Wrong identifier or parity logic shows in the first identifier read.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OFF,
        MD_READ,
        MD_PROG,
        MD_VERIFY,
        MD_INHIBIT,
        MD_IDENT
    } otp_mode_e;

    localparam logic [7:0] MAKER_ID = 8'h01;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      pgm_n,
    input  logic      vpp_hi,
    input  logic      a9_hv,
    output otp_mode_e mode
);
    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
        end else if (vpp_hi) begin
            if (!pgm_n)     mode = MD_PROG;
            else if (!oe_n) mode = MD_VERIFY;
            else            mode = MD_OFF;
        end else if (!pgm_n || oe_n) begin
            mode = MD_OFF;
        end else begin
            mode = a9_hv ? MD_IDENT : MD_READ;
        end
    end
endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
    import otp_pkg::*;
#(
    parameter int DEV_SEL = 0
) (
    input  logic       pick_dev,
    output logic [7:0] id_byte
);
    logic [7:0] dev_code;

    generate
        if (DEV_SEL == 1) begin : g_dev1
            assign dev_code = 8'h89;
        end else if (DEV_SEL == 2) begin : g_dev2
            assign dev_code = 8'h04;
        end else begin : g_dev0
            assign dev_code = 8'h08;
        end
    endgenerate

    assign id_byte = pick_dev ? dev_code : MAKER_ID;
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (wr_en) begin
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
    import otp_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int RD_LAT  = 2,
    parameter int DEV_SEL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    localparam int CNT_W = $clog2(RD_LAT) + 1;
    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(RD_LAT - 1);

    typedef struct packed {
        logic              armed;
        logic [ADDR_W-1:0] pg_addr;
        logic [7:0]        pg_data;
        logic [CNT_W-1:0]  run;
        logic [7:0]        dout;
        logic              dout_en;
    } state_t;

    state_t    st_d, st_q;
    otp_mode_e mode;
    logic [7:0] cell_byte, id_byte, out_byte;
    logic       wr_en, active;

    otp_mode_decode u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .a9_hv  (a9_hv),
        .mode   (mode)
    );

    otp_id_rom #(.DEV_SEL(DEV_SEL)) u_id (
        .pick_dev (addr[0]),
        .id_byte  (id_byte)
    );

    otp_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (st_q.pg_addr),
        .wr_data (st_q.pg_data),
        .rd_addr (addr),
        .rd_data (cell_byte)
    );

    // commit once when the strobe is first seen high after a program cycle
    assign wr_en    = st_q.armed && pgm_n;
    assign active   = (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_IDENT);
    assign out_byte = (mode == MD_IDENT) ? id_byte : cell_byte;

    always_comb begin
        st_d       = st_q;
        st_d.armed = (mode == MD_PROG);
        if (mode == MD_PROG) begin
            st_d.pg_addr = addr;
            st_d.pg_data = din;
        end
        if (active) begin
            if (st_q.run >= LAST_WAIT) begin
                st_d.dout_en = 1'b1;
                st_d.dout    = out_byte;
            end else begin
                st_d.run     = st_q.run + 1'b1;
                st_d.dout_en = 1'b0;
            end
        end else begin
            st_d.run     = '0;
            st_d.dout_en = 1'b0;
            st_d.dout    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.dout;
    assign dout_en = st_q.dout_en;
endmodule

// File: rtl/otp_byte_mem_checker.sv
module otp_byte_mem_checker #(
    parameter int ADDR_W = 10,
    parameter int RD_LAT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic              vpp_hi,
    input logic              a9_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dout,
    input logic              dout_en
);
    localparam int RW = $clog2(RD_LAT + 1) + 1;

    logic [RW-1:0] run_q;
    logic          want;

    assign want = !ce_n && !oe_n && pgm_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        run_q <= '0;
        else if (!want)                    run_q <= '0;
        else if (run_q < RW'(RD_LAT))      run_q <= run_q + 1'b1;
    end

    a_r4_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hi) |=> !dout_en);
    a_r5_disable_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> !dout_en);
    a_r7_program_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_hi && !pgm_n) |=> !dout_en);
    a_r9_inhibit_float: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && vpp_hi) |=> !dout_en);
    a_r13_strobe_no_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !vpp_hi && !pgm_n) |=> !dout_en);
    a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en == (run_q >= RW'(RD_LAT)));
    a_r10_maker_code: assert property (@(posedge clk) disable iff (!rst_n)
        (want && a9_hv && !vpp_hi && !addr[0]) |=> (!dout_en || dout == 8'h01));
    a_r11_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (want && a9_hv && !vpp_hi) |=> (!dout_en || (^dout) == 1'b1));
endmodule

bind otp_byte_mem otp_byte_mem_checker #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .pgm_n   (pgm_n),
    .vpp_hi  (vpp_hi),
    .a9_hv   (a9_hv),
    .addr    (addr),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/otp_byte_mem_test.sv
`timescale 1ns/1ps
module otp_byte_mem_test;
    localparam int AW  = 10;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n, ce_n, oe_n, pgm_n, vpp_hi, a9_hv;
    logic [AW-1:0] addr;
    logic [7:0]    din, dout;
    logic          dout_en;
    logic [7:0]    model [1 << AW];
    int            n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    otp_byte_mem #(.ADDR_W(AW), .RD_LAT(LAT), .DEV_SEL(0)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [7:0] exp_id(logic a0);
        return a0 ? 8'h08 : 8'h01;
    endfunction

    task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1;
        vpp_hi = 1'b0; a9_hv = 1'b0; din = 8'h00;
    endtask

    // R7: program pulse with the strobe held low for `hold` cycles
    task automatic do_prog(logic [AW-1:0] a, logic [7:0] d, int hold);
        ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b1; addr = a; din = d;
        tick(1);
        pgm_n = 1'b0;
        tick(hold);
        check(dout_en == 1'b0, "R7 outputs off in program", {7'b0, dout_en}, 8'h00);
        pgm_n = 1'b1;
        tick(1);
        idle();
        tick(1);
        model[a] = model[a] & d;
    endtask

    // R12: latency, then float after output enable rises
    task automatic do_read(logic [AW-1:0] a, logic vpp, logic a9, output logic [7:0] v);
        idle();
        ce_n = 1'b0; oe_n = 1'b0; vpp_hi = vpp; a9_hv = a9; addr = a;
        if (LAT > 1) begin
            tick(LAT - 1);
            check(dout_en == 1'b0, "R12 not yet valid", {7'b0, dout_en}, 8'h00);
        end
        tick(1);
        check(dout_en == 1'b1, "R12 valid after latency", {7'b0, dout_en}, 8'h01);
        v = dout;
        oe_n = 1'b1;
        tick(1);
        check(dout_en == 1'b0, "R12 float after oe rises", {7'b0, dout_en}, 8'h00);
        idle();
        tick(1);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
        idle(); addr = '0; rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(dout_en == 1'b0, "R4 reset state", {7'b0, dout_en}, 8'h00);

        // R1 blank array
        do_read(10'd0, 1'b0, 1'b0, v);    check(v == 8'hFF, "R1 blank low", v, 8'hFF);
        do_read(10'd1023, 1'b0, 1'b0, v); check(v == 8'hFF, "R1 blank high", v, 8'hFF);

        // R2 AND of old and new, R6 read, R8 verify
        do_prog(10'd3, 8'h5A, 3);
        do_read(10'd3, 1'b0, 1'b0, v); check(v == 8'h5A, "R6 read programmed", v, 8'h5A);
        do_prog(10'd3, 8'hF0, 3);
        do_read(10'd3, 1'b1, 1'b0, v); check(v == 8'h50, "R2 and R8 verify", v, 8'h50);
        do_prog(10'd3, 8'hFF, 3);
        do_read(10'd3, 1'b0, 1'b0, v); check(v == 8'h50, "R2 no bit set back", v, 8'h50);

        // R3 long hold writes once
        do_prog(10'd4, 8'h3C, 40);
        do_read(10'd4, 1'b0, 1'b0, v); check(v == 8'h3C, "R3 long hold", v, 8'h3C);

        // R3 chip enable rises before the strobe: no write
        ce_n = 1'b0; vpp_hi = 1'b1; addr = 10'd5; din = 8'h00; pgm_n = 1'b0;
        tick(2);
        ce_n = 1'b1; tick(1);
        pgm_n = 1'b1; tick(2);
        idle(); tick(1);
        do_read(10'd5, 1'b0, 1'b0, v); check(v == 8'hFF, "R3 aborted pulse", v, 8'hFF);

        // R9 inhibit
        ce_n = 1'b1; oe_n = 1'b0; vpp_hi = 1'b1; addr = 10'd6; din = 8'h00; pgm_n = 1'b0;
        tick(3);
        check(dout_en == 1'b0, "R9 inhibit float", {7'b0, dout_en}, 8'h00);
        pgm_n = 1'b1; tick(2);
        idle(); tick(1);
        do_read(10'd6, 1'b0, 1'b0, v); check(v == 8'hFF, "R9 inhibit no write", v, 8'hFF);

        // R4 standby with oe low, R5 output disable
        ce_n = 1'b1; oe_n = 1'b0; addr = 10'd3; tick(3);
        check(dout_en == 1'b0, "R4 standby float", {7'b0, dout_en}, 8'h00);
        ce_n = 1'b0; oe_n = 1'b1; tick(3);
        check(dout_en == 1'b0, "R5 output disable", {7'b0, dout_en}, 8'h00);
        idle(); tick(1);

        // R13 strobe without supply
        ce_n = 1'b0; oe_n = 1'b0; addr = 10'd7; din = 8'h00; pgm_n = 1'b0;
        tick(3);
        check(dout_en == 1'b0, "R13 strobe without supply float", {7'b0, dout_en}, 8'h00);
        pgm_n = 1'b1; tick(1);
        idle(); tick(1);
        do_read(10'd7, 1'b0, 1'b0, v); check(v == 8'hFF, "R13 no write", v, 8'hFF);

        // R10, R11 identifier bytes
        for (int b = 0; b < 2; b++) begin
            do_read(AW'(b), 1'b0, 1'b1, v);
            check(v == exp_id(b[0]), "R10 identifier", v, exp_id(b[0]));
            check((^v) == 1'b1, "R11 odd parity", {7'b0, ^v}, 8'h01);
        end

        // R12 float after chip enable rises
        ce_n = 1'b0; oe_n = 1'b0; addr = 10'd3; tick(LAT);
        check(dout_en == 1'b1 && dout == model[3], "R12 open", dout, model[3]);
        ce_n = 1'b1; tick(1);
        check(dout_en == 1'b0, "R12 float after ce rises", {7'b0, dout_en}, 8'h00);
        idle(); tick(1);

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [AW-1:0] ra;
            logic [7:0]    rd;
            int            op;
            ra = AW'($urandom_range(8, 23));
            rd = 8'($urandom);
            op = $urandom_range(0, 2);
            if (op == 0) begin
                do_prog(ra, rd, $urandom_range(1, 6));
            end else begin
                do_read(ra, op == 2, 1'b0, v);
                check(v == model[ra], op == 2 ? "R8 random verify" : "R6 random read",
                      v, model[ra]);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule